// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Counter

This block is a 16-bit timer whose whole behaviour is set by one 16-bit control word. Software picks which of four clock-enable inputs drives the timer, a prescale ratio of 1, 2, 4 or 8, and one of four counting modes. The modes are halted, up to a period value, free-running over the full range, and a triangle mode that climbs to the period value and then descends to zero.

A clear command in the same word resets the count, the prescaler and the count direction. Each counting mode has a turning event: the wrap in up mode, the wrap in free-running mode, and the arrival at zero on the way down in triangle mode. That event raises a pending flag. The flag is ANDed with an enable bit to form the interrupt request.

The counting direction is held by a two-state machine. RISE is the state after reset and after a clear. The RISE_TO_FALL transition happens when the count reaches the period in triangle mode and the step down leaves a nonzero value. The FALL_TO_RISE transition happens when the count returns to zero. The FORCE_RISE transition is taken on any clear, and on any advance in up or free-running mode.

Top module: `mm_timer16`

## Requirements
- R1: The control word reads back the source select in bits 9:8, the prescale select in bits 7:6, the mode in bits 5:4, the interrupt enable in bit 1 and the pending flag in bit 0. Bits 15:10, bit 3 and bit 2 always read 0 and ignore writes. Every field is 0 after reset. A written field takes effect from the next cycle.
- R2: Writing 1 to bit 2 sets the count to 0 at the next edge. It also restarts the prescaler and returns the direction to rising. No advance happens in that cycle.
- R3: Source select values 0, 1, 2 and 3 choose tick_in[0], tick_in[1], tick_in[2] and tick_in[3]. The prescaler counts only on cycles where the chosen input is high.
- R4: Prescale select values 00, 01, 10 and 11 make the counter advance on every 1st, 2nd, 4th and 8th qualifying tick. A write that changes the prescale field restarts the prescale count, and no advance happens in that cycle.
- R5: Mode 00 (halted) holds the count and the prescaler.
- R6: Mode 01 (up) increments the count. An advance taken when the count is at or above the period gives 0 and sets the flag.
- R7: Mode 10 (free-running) increments the count. An advance taken at 0xFFFF gives 0 and sets the flag.
- R8: Mode 11 (up/down) increments the count while below the period and then decrements. When a decrement reaches 0, the flag is set and counting rises again. With a period of 0 the count stays at 0 and every advance sets the flag.
- R9: irq equals the pending flag ANDed with the enable bit.
- R10: Writing 0 to bit 0 clears the flag. A hardware set in the same cycle wins over that clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| ctrl_rd | output | 16 | Control word read value |
| tick_in | input | 4 | Clock-enable inputs, one per selectable source |
| period | input | 16 | Period value for up and up/down modes |
| count | output | 16 | Current count |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a software clear of the flag landing in the same cycle as a hardware set. The stimulus reaches it by running up mode with a period of 0 and every tick high, so that a wrap happens on every cycle, and then writing the flag to 0 several times in a row. The 0xFFFF wrap of free-running mode needs 65536 advances, so it is driven with prescale 1 and constant ticks. A clear is issued while the count is descending in up/down mode, which checks that the direction is reset. A prescale change in the middle of a run checks the prescaler restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REG_W    = 16;
    localparam int FLAG_B   = 0;
    localparam int IE_B     = 1;
    localparam int CLR_B    = 2;
    localparam int MODE_LSB = 4;
    localparam int DIV_LSB  = 6;
    localparam int SRC_LSB  = 8;

    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_UP   = 2'b01,
        MODE_FREE = 2'b10,
        MODE_UPDN = 2'b11
    } mode_e;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } dir_e;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
    import tmr_pkg::*;
#(
    parameter int SRC_W = 2,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             hw_set,
    output logic [SRC_W-1:0] src_sel,
    output logic [DIV_W-1:0] div_sel,
    output mode_e            mode,
    output logic             irq_en,
    output logic             flag,
    output logic             clr_pulse,
    output logic             div_restart,
    output logic [REG_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= '0;
            div_sel <= '0;
            mode    <= MODE_HALT;
            irq_en  <= 1'b0;
            flag    <= 1'b0;
        end else begin
            if (wr_en) begin
                src_sel <= wr_data[SRC_LSB +: SRC_W];
                div_sel <= wr_data[DIV_LSB +: DIV_W];
                mode    <= mode_e'(wr_data[MODE_LSB +: 2]);
                irq_en  <= wr_data[IE_B];
            end
            if (hw_set)
                flag <= 1'b1;
            else if (wr_en)
                flag <= wr_data[FLAG_B];
        end
    end

    always_comb begin
        clr_pulse   = wr_en & wr_data[CLR_B];
        div_restart = wr_en && (wr_data[DIV_LSB +: DIV_W] != div_sel);
    end

    always_comb begin
        rd_data = '0;
        rd_data[SRC_LSB +: SRC_W] = src_sel;
        rd_data[DIV_LSB +: DIV_W] = div_sel;
        rd_data[MODE_LSB +: 2]    = mode;
        rd_data[IE_B]             = irq_en;
        rd_data[FLAG_B]           = flag;
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_sel,
    output logic             adv
);
    localparam int MAX_LOG = (1 << DIV_W) - 1;
    localparam int PCW     = (MAX_LOG < 1) ? 1 : MAX_LOG;

    logic [PCW-1:0] pcnt;
    logic [PCW-1:0] term;
    logic           at_term;

    always_comb begin
        term    = PCW'((1 << div_sel) - 1);
        at_term = (pcnt >= term);
        adv     = run & tick & ~restart & at_term;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else if (restart)
            pcnt <= '0;
        else if (run && tick)
            pcnt <= at_term ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    dir_e             dir_q, dir_d;
    logic [CNT_W-1:0] cnt_d;

    // state register: direction and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_RISE;
            count <= '0;
        end else begin
            dir_q <= dir_d;
            count <= cnt_d;
        end
    end

    // next state and turning-event output
    always_comb begin
        dir_d = dir_q;
        cnt_d = count;
        wrap  = 1'b0;
        if (clr) begin
            dir_d = DIR_RISE;
            cnt_d = '0;
        end else if (adv) begin
            unique case (mode)
                MODE_HALT: begin
                    cnt_d = count;
                end
                MODE_UP: begin
                    dir_d = DIR_RISE;
                    if (count >= period) begin
                        cnt_d = '0;
                        wrap  = 1'b1;
                    end else begin
                        cnt_d = count + ONE;
                    end
                end
                MODE_FREE: begin
                    dir_d = DIR_RISE;
                    cnt_d = count + ONE;
                    wrap  = (count == ALL_ONES);
                end
                MODE_UPDN: begin
                    unique case (dir_q)
                        DIR_RISE: begin
                            if (count < period) begin
                                cnt_d = count + ONE;
                            end else if (count == '0) begin
                                wrap = 1'b1;
                            end else begin
                                cnt_d = count - ONE;
                                if (count == ONE)
                                    wrap = 1'b1;
                                else
                                    dir_d = DIR_FALL;
                            end
                        end
                        DIR_FALL: begin
                            if (count <= ONE) begin
                                cnt_d = '0;
                                wrap  = 1'b1;
                                dir_d = DIR_RISE;
                            end else begin
                                cnt_d = count - ONE;
                            end
                        end
                        default: dir_d = DIR_RISE;
                    endcase
                end
                default: cnt_d = count;
            endcase
        end
    end
endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NSRC  = 4,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctrl_rd,
    input  logic [NSRC-1:0]  tick_in,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [SRC_W-1:0] src_sel;
    logic [DIV_W-1:0] div_sel;
    mode_e            mode;
    logic             irq_en, flag, clr_pulse, div_restart;
    logic             tick, run, adv, wrap;

    tmr_ctrl_reg #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hw_set(wrap), .src_sel(src_sel), .div_sel(div_sel), .mode(mode),
        .irq_en(irq_en), .flag(flag), .clr_pulse(clr_pulse),
        .div_restart(div_restart), .rd_data(ctrl_rd)
    );

    always_comb begin
        tick = tick_in[src_sel];
        run  = (mode != MODE_HALT);
        irq  = flag & irq_en;
    end

    tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
        .restart(clr_pulse | div_restart), .div_sel(div_sel), .adv(adv)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_pulse), .adv(adv), .mode(mode),
        .period(period), .count(count), .wrap(wrap)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [15:0]      wr_data,
    input logic [15:0]      ctrl_rd,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] count,
    input logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[15:10] == 6'd0) && (ctrl_rd[3:2] == 2'd0)); // R1

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2]) |=> (count == '0)); // R2

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[5:4] == 2'b00 && !(wr_en && wr_data[2])) |=> $stable(count)); // R5

    AST_UP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[5:4] == 2'b01 && count <= period && !(wr_en && wr_data[2]))
        |=> (count <= $past(period))); // R6

    AST_FREE_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_rd[5:4]) == 2'b10 && $past(count) == '1 && count == '0
         && !$past(wr_en && wr_data[2])) |-> ctrl_rd[0]); // R7

    AST_UPDN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_rd[5:4]) == 2'b11 && !$past(wr_en && wr_data[2]))
        |-> (count == $past(count) || count == $past(count) + ONE
             || count == $past(count) - ONE)); // R8

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ctrl_rd[1] & ctrl_rd[0])); // R9
endmodule

bind mm_timer16 tmr_checker #(.CNT_W(CNT_W)) u_tmr_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .period(period), .count(count), .irq(irq)
);

// File: tb/mm_timer16_bench.sv
`timescale 1ns/1ps
module mm_timer16_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] ctrl_rd;
    logic [3:0]  tick_in = '0;
    logic [15:0] period = '0;
    logic [15:0] count;
    logic        irq;

    int n_chk = 0, n_err = 0, cyc = 0, tick_mode = 0;
    string ph = "R1";

    // behavioural reference state
    int m_src, m_div, m_mode, m_ie, m_flag, m_pcnt, m_cnt, m_down;
    int adv, hw;
    bit clr_now;

    always #2 clk = ~clk;

    mm_timer16 u_mm_timer16 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .tick_in(tick_in), .period(period),
        .count(count), .irq(irq)
    );

    function automatic logic [15:0] mk(int src, int dv, int md, int ie, int fl, int cl);
        return 16'((src << 8) | (dv << 6) | (md << 4) | (cl << 2) | (ie << 1) | fl);
    endfunction

    function automatic string mtag(int md);
        case (md)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s/%s %s actual=%0h expected=%0h", tag, ph, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_src = 0; m_div = 0; m_mode = 0; m_ie = 0; m_flag = 0;
            m_pcnt = 0; m_cnt = 0; m_down = 0;
        end else begin
            adv = 0; hw = 0;
            clr_now = wr_en && wr_data[2];
            if (clr_now) begin
                m_pcnt = 0; m_cnt = 0; m_down = 0;
            end else begin
                if (wr_en && int'(wr_data[7:6]) != m_div) m_pcnt = 0;
                else if (m_mode != 0 && tick_in[m_src]) begin
                    if (m_pcnt + 1 >= (1 << m_div)) begin m_pcnt = 0; adv = 1; end
                    else m_pcnt++;
                end
                if (adv != 0) begin
                    if (m_mode == 1) begin
                        m_down = 0;
                        if (m_cnt >= int'(period)) begin m_cnt = 0; hw = 1; end else m_cnt++;
                    end else if (m_mode == 2) begin
                        m_down = 0;
                        if (m_cnt == 65535) begin m_cnt = 0; hw = 1; end else m_cnt++;
                    end else if (m_mode == 3) begin
                        if (m_down == 0) begin
                            if (m_cnt < int'(period)) m_cnt++;
                            else if (m_cnt == 0) hw = 1;
                            else begin
                                m_cnt--;
                                if (m_cnt == 0) hw = 1; else m_down = 1;
                            end
                        end else if (m_cnt <= 1) begin
                            m_cnt = 0; hw = 1; m_down = 0;
                        end else m_cnt--;
                    end
                end
            end
            if (hw != 0) m_flag = 1;
            else if (wr_en) m_flag = int'(wr_data[0]);
            if (wr_en) begin
                m_src = int'(wr_data[9:8]); m_div = int'(wr_data[7:6]);
                m_mode = int'(wr_data[5:4]); m_ie = int'(wr_data[1]);
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(count) == m_cnt, mtag(m_mode), "count", int'(count), m_cnt);
            chk(int'(ctrl_rd) == ((m_src << 8) | (m_div << 6) | (m_mode << 4) | (m_ie << 1) | m_flag),
                "R1", "ctrl_rd", int'(ctrl_rd),
                (m_src << 8) | (m_div << 6) | (m_mode << 4) | (m_ie << 1) | m_flag);
            chk(int'(irq) == (m_flag & m_ie), "R9", "irq", int'(irq), m_flag & m_ie);
        end
        case (tick_mode)
            0: tick_in = 4'hF;
            1: tick_in = 4'($urandom);
            default: tick_in = 4'h0;
        endcase
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
        end
    end

    task automatic wr(logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        ph = "R1"; idle(3);                          // reset state: all zero
        wr(16'hFC0C);                                // reserved bits and clear ignored on read
        idle(3);
        ph = "R6"; period = 16'd5; tick_mode = 0;
        wr(mk(0, 0, 1, 1, 0, 0)); idle(30);
        ph = "R10"; wr(mk(0, 0, 1, 1, 0, 0)); idle(5);
        ph = "R3"; tick_mode = 1;
        for (int s = 0; s < 4; s++) begin
            wr(mk(s, 0, 1, 1, 0, 1)); idle(40);
        end
        ph = "R4"; period = 16'd9;
        for (int d = 0; d < 4; d++) begin
            tick_mode = 0; wr(mk(1, d, 1, 1, 0, 1)); idle(50);
            tick_mode = 1; idle(50);
        end
        tick_mode = 0;
        wr(mk(1, 3, 1, 0, 0, 0)); idle(5);
        wr(mk(1, 1, 1, 0, 0, 0)); idle(20);          // prescale change mid-run
        ph = "R5"; wr(mk(1, 1, 0, 1, 1, 0)); idle(20);
        ph = "R8"; period = 16'd7;
        wr(mk(2, 0, 3, 1, 0, 1)); idle(40);
        ph = "R2"; wr(mk(2, 0, 3, 1, 0, 0)); idle(10); // now descending
        wr(mk(2, 0, 3, 1, 0, 1)); idle(30);
        ph = "R8"; period = 16'd3; idle(20);
        period = 16'd1; idle(10);
        period = 16'd0; idle(10);
        tick_mode = 1; period = 16'd6; wr(mk(3, 1, 3, 0, 0, 1)); idle(80);
        ph = "R10"; tick_mode = 0; period = 16'd0;
        wr(mk(0, 0, 1, 1, 0, 1));
        for (int k = 0; k < 10; k++) wr(mk(0, 0, 1, 1, 0, 0));
        tick_mode = 2; idle(2);
        wr(mk(0, 0, 1, 1, 0, 0)); idle(3);           // no collision: flag clears
        ph = "R7"; tick_mode = 0;
        wr(mk(0, 0, 2, 0, 0, 1)); idle(100);
        wr(mk(0, 0, 2, 1, 0, 0)); idle(65500);
        idle(20);
        summary();
    end
endmodule